// File: doc/BRIEF.md
# Exception Entry Sequencer with Late-Arrival Retargeting

This block performs the hardware side of entering an exception handler on a small microcontroller-style core. When the prioritised request input shows a pending exception and the block is idle, it takes a snapshot of the caller-saved registers, the return PC and the status word. It then pushes them as an eight-word frame below the current stack pointer, one write per accepted bus cycle. While those writes are still going on, it reads the handler address from a vector table through a separate read port. Once the frame is fully written and a valid handler address is held, it gives the core a one-cycle start strobe with the handler PC, the new stack pointer, the link-register return code and one-hot pending-clear / active-set pulses.

A request with a strictly better priority can arrive while the entry is in progress. In that case the block retargets to the new exception. The frame already written is kept, and its contents are unchanged. The vector read is redone for the new number. A read response still in flight for the old number is thrown away, whatever it carries. The earlier exception's pending bit is not touched.

If the vector read for the current target reports a bus error, the entry is abandoned. A one-cycle fault report with a vector-error cause is raised instead of a handler start.

Top module: `excEntryTop`

## Requirements
- R1: Word k of the frame (k = 0..7) is written to address spIn - 32 + 4k, in ascending k order. The words, in k order, are saveRegs[0..5] (R0, R1, R2, R3, R12, LR), then retPc, then saveRegs[6] (status word). All values are sampled when the entry is accepted.
- R2: At handlerStart, spOut equals spIn - 32, which is the lowest address of the frame.
- R3: A write is transferred in each cycle where wrValid and wrReady are both high. While wrReady is low, wrValid, wrAddr and wrData hold their values.
- R4: The vector read (rdReq) is raised while frame writes are still outstanding. It stays asserted with a stable rdAddr until rdAck.
- R5: handlerStart is a one-cycle pulse. It comes only after all eight frame writes have been accepted and a good vector response has been captured.
- R6: lrOut is 0xFFFFFFF1 when inHandler=1. It is 0xFFFFFFF9 for thread mode with usePsp=0, and 0xFFFFFFFD for thread mode with usePsp=1.
- R7: handlerPc equals the accepted vector data with bit 0 forced to 0. The vector address is vecBase + 4 × exception number.
- R8: In the handlerStart cycle, pendClr and actSet both equal 1 << final exception number. At all other times both are zero.
- R9: During an entry, a request with reqPrio numerically lower than the current target's priority retargets the entry. A lower value means a higher priority. After a retarget, no extra frame write is made, the vector read goes to the new number's address, and only the new number's bit is cleared. A request with an equal or higher reqPrio value has no effect.
- R10: A rdErr on the current target's vector response ends the entry. faultPulse is then high for one cycle with faultCause = 2'b01. No handlerStart and no pending/active pulse follow. The block then returns to idle and accepts the next request.
- R11: A vector response that arrives for a target that has since been replaced is discarded. Neither its data nor its rdErr has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A pending exception is presented |
| reqNum | input | NumW | Number of the highest-priority pending exception |
| reqPrio | input | PrioW | Its priority; a lower value is more urgent |
| spIn | input | 32 | Current stack pointer (word aligned) |
| inHandler | input | 1 | Core is in handler mode |
| usePsp | input | 1 | Thread mode is running on the process stack |
| retPc | input | 32 | Address of the next instruction of the interrupted code |
| saveRegs | input | 7x32 | R0, R1, R2, R3, R12, LR, status word (index 0..6) |
| vecBase | input | 32 | Vector table base address |
| wrValid | output | 1 | Frame write request |
| wrAddr | output | 32 | Frame write address |
| wrData | output | 32 | Frame write data |
| wrReady | input | 1 | Write bus accepts the write this cycle |
| rdReq | output | 1 | Vector read request |
| rdAddr | output | 32 | Vector read address |
| rdAck | input | 1 | Vector read response valid |
| rdData | input | 32 | Vector read data |
| rdErr | input | 1 | Vector read bus error |
| handlerStart | output | 1 | One-cycle handler start strobe |
| handlerPc | output | 32 | Handler start address |
| lrOut | output | 32 | Return code for the link register |
| spOut | output | 32 | Updated stack pointer |
| spIsPsp | output | 1 | The frame is on the process stack |
| pendClr | output | NumExc | One-hot pending-clear pulse |
| actSet | output | NumExc | One-hot active-set pulse |
| faultPulse | output | 1 | One-cycle fault report |
| faultCause | output | 2 | Fault cause; 2'b01 is a vector read error |

## Verification
The assertions assume a well-behaved read port: rdAck comes only while rdReq is high, there is one single-cycle response per request, and rdErr counts only alongside rdAck. They also assume spIn is word aligned, and that the requester withdraws or updates reqValid once handlerStart or faultPulse is seen. The bench's read responder follows exactly that protocol, using a programmable latency. Its write slave stalls in fixed patterns. The driver drops reqValid in the same half-cycle in which it sees the start or fault pulse, so an entry is never re-triggered by a stale request.

// File: rtl/excEntryPkg.sv
package excEntryPkg;
  localparam int FrameWords = 8;
  localparam int FrameBytes = FrameWords * 4;
  localparam logic [31:0] RetToHandler   = 32'hFFFF_FFF1;
  localparam logic [31:0] RetToThreadMsp = 32'hFFFF_FFF9;
  localparam logic [31:0] RetToThreadPsp = 32'hFFFF_FFFD;
  localparam logic [1:0]  CauseVecErr    = 2'b01;

  typedef struct packed {
    logic latchEntry;
    logic retarget;
    logic issueRead;
    logic captureVec;
    logic startHandler;
  } ctrlStrobes_t;
endpackage

// File: rtl/excEntryCtrl.sv
module excEntryCtrl
  import excEntryPkg::*;
#(
  parameter int IdxW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            lateHit,
  input  logic            wrReady,
  input  logic            rdAck,
  input  logic            rdErr,
  output ctrlStrobes_t    strobes,
  output logic            wrValid,
  output logic [IdxW-1:0] wrIdx,
  output logic            rdReq,
  output logic            handlerStart,
  output logic            faultPulse,
  output logic [1:0]      faultCause
);
  typedef enum logic {Idle, Entry} state_t;
  state_t st;

  logic [IdxW-1:0] idx;
  logic rdPend, stale, vecOk;
  logic active, late, stackDone, pushWord, ackSeen, ackGood, abortNow;

  always_comb begin
    active    = (st == Entry);
    late      = active && lateHit;
    stackDone = (idx == IdxW'(FrameWords));
    pushWord  = active && !stackDone && wrReady;
    ackSeen   = rdPend && rdAck;
    ackGood   = ackSeen && !stale && !late;
    abortNow  = ackGood && rdErr;
    strobes.latchEntry   = !active && reqValid;
    strobes.retarget     = late;
    strobes.issueRead    = active && !rdPend && !vecOk && !late;
    strobes.captureVec   = ackGood && !rdErr;
    strobes.startHandler = active && stackDone && vecOk && !late;
  end

  assign wrValid = active && !stackDone;
  assign wrIdx   = idx;
  assign rdReq   = rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st           <= Idle;
      idx          <= '0;
      rdPend       <= 1'b0;
      stale        <= 1'b0;
      vecOk        <= 1'b0;
      handlerStart <= 1'b0;
      faultPulse   <= 1'b0;
      faultCause   <= '0;
    end else begin
      handlerStart <= strobes.startHandler;
      faultPulse   <= abortNow;
      faultCause   <= abortNow ? CauseVecErr : 2'b00;
      if (strobes.latchEntry) begin
        st     <= Entry;
        idx    <= '0;
        rdPend <= 1'b0;
        stale  <= 1'b0;
        vecOk  <= 1'b0;
      end else if (active) begin
        if (pushWord) idx <= idx + 1'b1;
        if (strobes.issueRead) begin
          rdPend <= 1'b1;
        end else if (ackSeen) begin
          rdPend <= 1'b0;
          stale  <= 1'b0;
        end
        if (late) begin
          vecOk <= 1'b0;
          if (rdPend && !rdAck) stale <= 1'b1;
        end else if (strobes.captureVec) begin
          vecOk <= 1'b1;
        end
        if (strobes.startHandler || abortNow) st <= Idle;
      end
    end
  end

  // R10: a fault report never coincides with a handler start
  assert_fault_no_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> !handlerStart);

  // R11: a response for a replaced target cannot raise a fault
  assert_stale_no_fault_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && rdAck && stale) |=> !faultPulse);
endmodule

// File: rtl/excEntryPath.sv
module excEntryPath
  import excEntryPkg::*;
#(
  parameter int NumExc = 32,
  parameter int NumW   = 5,
  parameter int PrioW  = 3,
  parameter int IdxW   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              reqValid,
  input  logic [NumW-1:0]   reqNum,
  input  logic [PrioW-1:0]  reqPrio,
  input  logic [31:0]       spIn,
  input  logic              inHandler,
  input  logic              usePsp,
  input  logic [31:0]       retPc,
  input  logic [6:0][31:0]  saveRegs,
  input  logic [31:0]       vecBase,
  input  logic [IdxW-1:0]   wrIdx,
  input  logic [31:0]       rdData,
  output logic              lateHit,
  output logic [31:0]       wrAddr,
  output logic [31:0]       wrData,
  output logic [31:0]       rdAddr,
  output logic [31:0]       handlerPc,
  output logic [31:0]       lrOut,
  output logic [31:0]       spOut,
  output logic              spIsPsp,
  output logic [NumExc-1:0] pendClr,
  output logic [NumExc-1:0] actSet
);
  localparam int SelW = $clog2(FrameWords);

  logic [FrameWords-1:0][31:0] srcWords, frame;
  logic [NumW-1:0]   curNum;
  logic [PrioW-1:0]  curPrio;
  logic [NumExc-1:0] statusQ;
  logic [31:0]       lrNext;

  for (genvar k = 0; k < FrameWords; k++) begin : g_src
    if (k < 6) begin : g_reg
      assign srcWords[k] = saveRegs[k];
    end else if (k == 6) begin : g_pc
      assign srcWords[k] = retPc;
    end else begin : g_psr
      assign srcWords[k] = saveRegs[6];
    end
  end

  always_comb begin
    if (inHandler)   lrNext = RetToHandler;
    else if (usePsp) lrNext = RetToThreadPsp;
    else             lrNext = RetToThreadMsp;
  end

  assign lateHit = reqValid && (reqPrio < curPrio);
  assign wrAddr  = spOut + {{(30-IdxW){1'b0}}, wrIdx, 2'b00};
  assign wrData  = frame[wrIdx[SelW-1:0]];
  assign pendClr = statusQ;
  assign actSet  = statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame     <= '0;
      curNum    <= '0;
      curPrio   <= '0;
      spOut     <= '0;
      spIsPsp   <= 1'b0;
      lrOut     <= '0;
      rdAddr    <= '0;
      handlerPc <= '0;
      statusQ   <= '0;
    end else begin
      if (strobes.latchEntry) begin
        frame   <= srcWords;
        curNum  <= reqNum;
        curPrio <= reqPrio;
        spOut   <= spIn - 32'(FrameBytes);
        spIsPsp <= !inHandler && usePsp;
        lrOut   <= lrNext;
      end else if (strobes.retarget) begin
        curNum  <= reqNum;
        curPrio <= reqPrio;
      end
      if (strobes.issueRead) rdAddr <= vecBase + (32'(curNum) << 2);
      if (strobes.captureVec) handlerPc <= {rdData[31:1], 1'b0};
      statusQ <= strobes.startHandler ? (NumExc'(1) << curNum) : '0;
    end
  end

  // R8: at most one exception is cleared and activated at a time
  assert_pend_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusQ) <= 1);

  // R6: the return code is always one of the three legal values
  assert_lr_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.latchEntry) |->
      (lrOut == RetToHandler || lrOut == RetToThreadMsp || lrOut == RetToThreadPsp));
endmodule

// File: rtl/excEntryTop.sv
module excEntryTop
  import excEntryPkg::*;
#(
  parameter int NumExc = 32,
  parameter int PrioW  = 3,
  localparam int NumW  = $clog2(NumExc),
  localparam int IdxW  = $clog2(FrameWords + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NumW-1:0]   reqNum,
  input  logic [PrioW-1:0]  reqPrio,
  input  logic [31:0]       spIn,
  input  logic              inHandler,
  input  logic              usePsp,
  input  logic [31:0]       retPc,
  input  logic [6:0][31:0]  saveRegs,
  input  logic [31:0]       vecBase,
  output logic              wrValid,
  output logic [31:0]       wrAddr,
  output logic [31:0]       wrData,
  input  logic              wrReady,
  output logic              rdReq,
  output logic [31:0]       rdAddr,
  input  logic              rdAck,
  input  logic [31:0]       rdData,
  input  logic              rdErr,
  output logic              handlerStart,
  output logic [31:0]       handlerPc,
  output logic [31:0]       lrOut,
  output logic [31:0]       spOut,
  output logic              spIsPsp,
  output logic [NumExc-1:0] pendClr,
  output logic [NumExc-1:0] actSet,
  output logic              faultPulse,
  output logic [1:0]        faultCause
);
  ctrlStrobes_t    strobes;
  logic            lateHit;
  logic [IdxW-1:0] wrIdx;

  excEntryCtrl #(.IdxW(IdxW)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lateHit(lateHit),
    .wrReady(wrReady), .rdAck(rdAck), .rdErr(rdErr), .strobes(strobes),
    .wrValid(wrValid), .wrIdx(wrIdx), .rdReq(rdReq),
    .handlerStart(handlerStart), .faultPulse(faultPulse), .faultCause(faultCause)
  );

  excEntryPath #(.NumExc(NumExc), .NumW(NumW), .PrioW(PrioW), .IdxW(IdxW)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqValid(reqValid),
    .reqNum(reqNum), .reqPrio(reqPrio), .spIn(spIn), .inHandler(inHandler),
    .usePsp(usePsp), .retPc(retPc), .saveRegs(saveRegs), .vecBase(vecBase),
    .wrIdx(wrIdx), .rdData(rdData), .lateHit(lateHit), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .handlerPc(handlerPc), .lrOut(lrOut),
    .spOut(spOut), .spIsPsp(spIsPsp), .pendClr(pendClr), .actSet(actSet)
  );

  // Count of frame writes accepted since the last start or fault.
  logic [IdxW-1:0] acceptedWrites;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptedWrites <= '0;
    else if (handlerStart || faultPulse) acceptedWrites <= '0;
    else if (wrValid && wrReady) acceptedWrites <= acceptedWrites + 1'b1;
  end

  // R5: the handler only starts once the whole frame is on the stack
  assert_start_after_stack_R5: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |-> (acceptedWrites == IdxW'(FrameWords)));

  // R5: the start strobe lasts a single cycle
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |=> !handlerStart);

  // R3: a stalled write keeps its request and payload unless entry aborts
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ((wrValid && $stable(wrAddr) && $stable(wrData)) || faultPulse));

  // R4: the vector read is held with a stable address until answered
  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R7: the handler address given to the core is always even
  assert_pc_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |-> !handlerPc[0]);

  // R8: status pulses appear only with the start strobe
  assert_status_with_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr != '0) |-> handlerStart);
endmodule

// File: tb/test_excEntryTop.sv
`timescale 1ns/1ps
module test_excEntryTop;
  localparam int NumExc = 32;
  localparam int PrioW  = 3;
  localparam int NumW   = $clog2(NumExc);

  logic clk, rstN, reqValid, inHandler, usePsp, wrValid, wrReady, rdReq, rdAck, rdErr;
  logic handlerStart, spIsPsp, faultPulse;
  logic [NumW-1:0] reqNum;
  logic [PrioW-1:0] reqPrio;
  logic [31:0] spIn, retPc, vecBase, wrAddr, wrData, rdAddr, rdData, handlerPc, lrOut, spOut;
  logic [6:0][31:0] saveRegs;
  logic [NumExc-1:0] pendClr, actSet;
  logic [1:0] faultCause;

  excEntryTop #(.NumExc(NumExc), .PrioW(PrioW)) i_excEntryTop (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct { logic [31:0] pc, lr, sp; int num; } startItem_t;
  logic [63:0] wrQ[$];
  startItem_t  stQ[$];

  bit ignoreWr = 0, overlapSeen = 0, stallPrev = 0;
  int entryWrites = 0, faultsSeen = 0, startsSeen = 0;
  int stallMode = 0, rdLat = 0, rdWait = 0, cyc = 0;
  logic [31:0] lastRdAddr = '0, errAddr = 32'hFFFF_FFFF, stAddr, stData;

  function automatic logic [31:0] resp(input logic [31:0] a);
    return {~a[15:0], a[15:1], 1'b1};
  endfunction

  // Slave side: write ready pattern and vector read responder.
  always begin
    @(posedge clk); #1;
    cyc++;
    case (stallMode)
      0: wrReady = 1'b1;
      1: wrReady = cyc[0];
      default: wrReady = (cyc % 3 == 0);
    endcase
    if (rdAck) begin
      rdAck = 1'b0; rdErr = 1'b0;
    end else if (rdReq) begin
      if (rdWait == 0) begin
        rdAck = 1'b1; rdData = resp(rdAddr); rdErr = (rdAddr == errAddr); rdWait = rdLat;
      end else rdWait--;
    end
  end

  // Monitor / scoreboard.
  always @(negedge clk) if (rstN) begin
    if (stallPrev && !ignoreWr)
      chk(wrValid && wrAddr == stAddr && wrData == stData, "R3 stalled write held", wrAddr, stAddr);
    stallPrev = wrValid && !wrReady;
    stAddr = wrAddr; stData = wrData;
    if (wrValid && wrReady) begin
      entryWrites++;
      if (!ignoreWr) begin
        if (wrQ.size() == 0) chk(0, "R9 unexpected extra frame write", wrAddr, 0);
        else begin
          logic [63:0] e;
          e = wrQ.pop_front();
          chk(wrAddr == e[63:32] && wrData == e[31:0], "R1 frame word", wrData, e[31:0]);
          chk(wrAddr == e[63:32], "R1 frame address", wrAddr, e[63:32]);
        end
      end
    end
    if (rdReq) begin
      lastRdAddr = rdAddr;
      if (entryWrites < 8) overlapSeen = 1;
    end
    if (!handlerStart && (pendClr != '0 || actSet != '0))
      chk(0, "R8 status pulse outside start", pendClr, 0);
    if (handlerStart) begin
      startsSeen++;
      if (stQ.size() == 0) chk(0, "R5 unexpected start", handlerPc, 0);
      else begin
        startItem_t s;
        s = stQ.pop_front();
        chk(handlerPc == s.pc, "R7 handler pc", handlerPc, s.pc);
        chk(lrOut == s.lr, "R6 return code", lrOut, s.lr);
        chk(spOut == s.sp, "R2 stack pointer", spOut, s.sp);
        chk(pendClr == (NumExc'(1) << s.num), "R9 pending clear of final target", pendClr, NumExc'(1) << s.num);
        chk(actSet == (NumExc'(1) << s.num), "R8 active set", actSet, NumExc'(1) << s.num);
        chk(lastRdAddr == vecBase + 32'(s.num) * 4, "R7 vector address", lastRdAddr, vecBase + 32'(s.num) * 4);
        chk(entryWrites == 8, "R5 all writes before start", entryWrites, 8);
        chk(overlapSeen, "R4 vector read overlaps stacking", {31'b0, overlapSeen}, 1);
      end
      entryWrites = 0; overlapSeen = 0;
    end
    if (faultPulse) begin
      faultsSeen++;
      chk(faultCause == 2'b01, "R10 fault cause", faultCause, 2'b01);
      entryWrites = 0; overlapSeen = 0;
    end
  end

  task automatic runEntry(input int num, input int prio, input logic [31:0] sp, input bit hnd,
                          input bit psp, input int stall, input int lat, input int lateNum,
                          input int latePrio, input int lateAt, input bit lateTakes,
                          input bit vecErr, input bit errOld);
    int finalNum, f0, s0;
    bit done;
    startItem_t it;
    @(posedge clk); #1;
    stallMode = stall; rdLat = lat; rdWait = lat;
    spIn = sp; inHandler = hnd; usePsp = psp;
    retPc = 32'h0800_1000 + 32'(num) * 16 + 2;
    for (int k = 0; k < 7; k++) saveRegs[k] = 32'hA000_0000 | (32'(num) << 8) | 32'(k);
    finalNum = lateTakes ? lateNum : num;
    errAddr = (vecErr || errOld) ? vecBase + 32'(num) * 4 : 32'hFFFF_FFFF;
    f0 = faultsSeen; s0 = startsSeen;
    if (vecErr) ignoreWr = 1;
    else begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] d;
        d = (k < 6) ? saveRegs[k] : (k == 6) ? retPc : saveRegs[6];
        wrQ.push_back({sp - 32 + 32'(k) * 4, d});
      end
      it.pc = resp(vecBase + 32'(finalNum) * 4) & ~32'h1;
      it.lr = hnd ? 32'hFFFF_FFF1 : psp ? 32'hFFFF_FFFD : 32'hFFFF_FFF9;
      it.sp = sp - 32;
      it.num = finalNum;
      stQ.push_back(it);
    end
    reqValid = 1; reqNum = NumW'(num); reqPrio = PrioW'(prio);
    done = 0;
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk);
      if (handlerStart || faultPulse) begin
        done = 1; reqValid = 0;
      end else if (lateAt > 0 && c == lateAt) begin
        reqNum = NumW'(lateNum); reqPrio = PrioW'(latePrio);
      end
    end
    chk(done, "R5 entry completes", {31'b0, done}, 1);
    repeat (3) @(negedge clk);
    if (vecErr) begin
      chk(faultsSeen == f0 + 1, "R10 fault reported", faultsSeen, f0 + 1);
      chk(startsSeen == s0, "R10 no handler start", startsSeen, s0);
      chk(!wrValid && !rdReq, "R10 back to idle", {30'b0, wrValid, rdReq}, 0);
      wrQ.delete();
      ignoreWr = 0;
    end else begin
      chk(faultsSeen == f0, "R11 no fault on good entry", faultsSeen, f0);
      chk(wrQ.size() == 0, "R9 frame written exactly once", wrQ.size(), 0);
    end
    errAddr = 32'hFFFF_FFFF;
  endtask

  initial begin
    rstN = 0; reqValid = 0; reqNum = '0; reqPrio = '0; spIn = '0; inHandler = 0; usePsp = 0;
    retPc = '0; saveRegs = '0; vecBase = 32'h2000_0400; wrReady = 1; rdAck = 0; rdData = '0; rdErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!wrValid && !rdReq && !handlerStart && !faultPulse && pendClr == '0,
        "R5 reset state idle", {28'b0, wrValid, rdReq, handlerStart, faultPulse}, 0);
    // num prio sp hnd psp stall lat lateNum latePrio lateAt takes err errOld
    runEntry(5, 4, 32'h2000_8000, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0);   // R1 R2 R6 thread main stack
    runEntry(9, 3, 32'h2000_7F40, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);   // R3 R6 handler mode, stalls
    runEntry(17, 2, 32'h2000_6000, 0, 1, 0, 12, 0, 0, 0, 0, 0, 0); // R5 vector late vs stacking
    runEntry(6, 5, 32'h2000_5000, 0, 0, 0, 6, 12, 1, 3, 1, 0, 1);  // R9 R11 retarget, stale error
    runEntry(7, 3, 32'h2000_4800, 0, 1, 1, 1, 20, 3, 2, 0, 0, 0);  // R9 equal priority ignored
    runEntry(3, 6, 32'h2000_4000, 1, 1, 2, 0, 30, 0, 10, 1, 0, 0); // R9 retarget after vector done
    runEntry(11, 4, 32'h2000_3000, 0, 0, 0, 3, 0, 0, 0, 0, 1, 0);  // R10 vector error
    runEntry(12, 4, 32'h2000_2F00, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);  // R10 entry after fault
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    chk(0, "WATCHDOG expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule